// File: doc/BRIEF.md
# Configurable-width ROM read port

This block models the external read side of a 1M x 16 read-only memory as synchronous logic. Two active-low controls gate the outputs: a chip select that also acts as the standby control, and an output enable. A width-select input picks how the port is presented. In word mode all sixteen data lines carry the stored word. In byte mode only the low eight lines are driven, and the top data pin becomes an extra low address input that chooses which half of the stored word appears on those eight lines. The outputs come as a data vector plus a per-bit enable vector, so that a pad ring or a bus model can form the tristate bus.

Access time is modelled in clock cycles. One counter measures the time since the address, the width mode, the top-pin address bit, the identification flag or the chip select last changed. A second counter measures the time since the output enable fell. The valid flag, and with it the output enables, is raised only when both delays have passed. A digital flag stands for high-voltage identification sensing. While it is set, the block returns fixed identification codes in place of array contents. The storage is an internal register array that the environment fills through a simple preload port.

Top module: `rom_read_port`

## Requirements
- R1: In word mode (`word_mode`=1), with `ce_n`=0, `oe_n`=0 and the access complete, `dq_oe` is 16'hFFFF and `dq_out` equals the stored 16-bit word at the addressed location.
- R2: In byte mode (`word_mode`=0), a completed access drives only bits 7..0 (`dq_oe`=16'h00FF). `dq_out[7:0]` is bits 7..0 of the stored word when `top_pin_in`=0 and bits 15..8 when `top_pin_in`=1. Bits 15..8 of `dq_out` read 0.
- R3: With `ce_n`=0 and `oe_n`=1, `dq_oe` is zero and `data_valid` is low, without delay.
- R4: With `ce_n`=1, `dq_oe` is zero and `data_valid` is low whatever `oe_n` is, without delay.
- R5: With `id_mode`=1 and a completed access, the low byte is 8'h20 when `addr[0]`=0 and 8'hB1 when `addr[0]`=1. In word mode bits 15..8 read 0. In byte mode the code appears on bits 7..0 whatever `top_pin_in` is.
- R6: When `ce_n` falls while the other inputs are steady and `oe_n` is low, `data_valid` is low after the first T_ACC-1 rising edges and high after edge T_ACC. Edges are counted from the first edge that samples `ce_n` low as edge 0.
- R7: When `oe_n` falls while `ce_n` has been low and the address steady long enough, `data_valid` rises after edge T_OE (same counting), not before.
- R8: Any change of `addr`, `word_mode`, the byte-mode `top_pin_in` or `id_mode` lowers `data_valid` and `dq_oe` at once and restarts the T_ACC wait.
- R9: While `rst_n` is low, `data_valid` is low and `dq_oe` is zero.
- R10: Address bits at or above DEPTH_LOG2 do not select storage. Addresses that differ only in those bits return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low; high means standby |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = sixteen-bit port, 0 = eight-bit port |
| id_mode | input | 1 | Identification readout flag (stands for high-voltage sensing) |
| addr | input | ADDR_W | Word address |
| top_pin_in | input | 1 | Value seen on the shared top data pin; half select in byte mode |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | DEPTH_LOG2 | Preload location |
| pl_data | input | 16 | Preload word |
| dq_out | output | 16 | Data bus value; 0 on undriven bits |
| dq_oe | output | 16 | Per-bit output enable |
| data_valid | output | 1 | Access complete and outputs driven |

## Verification
Every stored word is read in word mode across an address range four times the array depth. This separates correct word fetch from aliasing faults in the unused upper bits. Every word is then read in byte mode with both settings of the top pin, which shows whether the halves are swapped and whether the upper lanes are released. The timing is probed one edge before and at the expected edge after a chip-select fall, an output-enable fall and each kind of input change, so that a delay that is off by one is caught. Identification reads are taken in both widths and with both values of address bit 0 and of the top pin, which separates the code path from the array path.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

   localparam int unsigned DQ_W   = 16;
   localparam int unsigned LANE_W = 8;

   typedef enum logic [1:0] {
      LANE_WORD    = 2'd0,
      LANE_BYTE_LO = 2'd1,
      LANE_BYTE_HI = 2'd2
   } lane_sel_e;

   function automatic lane_sel_e lane_pick(input logic wide, input logic half);
      if (wide)
         return LANE_WORD;
      else if (half)
         return LANE_BYTE_HI;
      else
         return LANE_BYTE_LO;
   endfunction

endpackage

// File: rtl/rom_store.sv
module rom_store #(
   parameter int unsigned DEPTH_LOG2 = 10,
   parameter int unsigned DATA_W     = 16
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [DEPTH_LOG2-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [DEPTH_LOG2-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data
);
   localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

   generate
      if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 16) begin : g_bad_depth
         $error("rom_store: DEPTH_LOG2 must lie in 1..16");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer #(
   parameter int unsigned T_ACC = 7,
   parameter int unsigned T_OE  = 4,
   parameter int unsigned KEY_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic [KEY_W-1:0] key,
   output logic             ready
);
   localparam int unsigned ACC_CW = $clog2(T_ACC + 1);
   localparam int unsigned OE_CW  = $clog2(T_OE + 1);
   localparam logic [ACC_CW-1:0] ACC_END = ACC_CW'(T_ACC);
   localparam logic [OE_CW-1:0]  OE_END  = OE_CW'(T_OE);

   generate
      if (T_ACC < 1) begin : g_bad_acc
         $error("rom_access_timer: T_ACC must be at least 1");
      end
      if (T_OE < 1) begin : g_bad_oe
         $error("rom_access_timer: T_OE must be at least 1");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("rom_access_timer: KEY_W must be at least 1");
      end
   endgenerate

   logic [KEY_W-1:0]  key_q;
   logic              ce_q;
   logic              oe_q;
   logic [ACC_CW-1:0] acc_cnt;
   logic [OE_CW-1:0]  oe_cnt;
   logic              key_moved;
   logic              acc_hold;
   logic              oe_hold;

   assign key_moved = (key != key_q);
   assign acc_hold  = ce_n | ce_q | key_moved;
   assign oe_hold   = ce_n | oe_n | oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q   <= '0;
         ce_q    <= 1'b1;
         oe_q    <= 1'b1;
         acc_cnt <= '0;
         oe_cnt  <= '0;
      end else begin
         key_q <= key;
         ce_q  <= ce_n;
         oe_q  <= oe_n;
         if (acc_hold)
            acc_cnt <= '0;
         else if (acc_cnt != ACC_END)
            acc_cnt <= acc_cnt + 1'b1;
         if (oe_hold)
            oe_cnt <= '0;
         else if (oe_cnt != OE_END)
            oe_cnt <= oe_cnt + 1'b1;
      end
   end

   assign ready = !ce_n && !oe_n && !key_moved
                  && (acc_cnt == ACC_END) && (oe_cnt == OE_END);

   // R8: an input change seen at an edge leaves no valid data on the following cycle
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_moved |=> !ready);

   // R6: valid data needs the chip selected at the edge before
   p_ce_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(!ce_n));

   // R7: valid data needs output enable low at the edge before
   p_oe_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(!oe_n));

endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
   import rom_port_pkg::*;
#(
   parameter logic [LANE_W-1:0] MFG_CODE = 8'h20,
   parameter logic [LANE_W-1:0] DEV_CODE = 8'hB1
) (
   input  logic              wide,
   input  logic              half,
   input  logic              id_mode,
   input  logic              id_sel,
   input  logic              drive,
   input  logic [DQ_W-1:0]   mem_word,
   output logic [DQ_W-1:0]   dq_out,
   output logic [DQ_W-1:0]   dq_oe
);
   localparam int unsigned HI_W = DQ_W - LANE_W;
   localparam logic [DQ_W-1:0] LOW_MASK = {{HI_W{1'b0}}, {LANE_W{1'b1}}};

   generate
      if (DQ_W != 2 * LANE_W) begin : g_bad_width
         $error("rom_lane_mux: data width must be two lanes");
      end
   endgenerate

   logic [DQ_W-1:0] id_word;
   logic [DQ_W-1:0] base;
   logic [DQ_W-1:0] shaped;
   logic [DQ_W-1:0] lane_mask;

   assign id_word = {{HI_W{1'b0}}, (id_sel ? DEV_CODE : MFG_CODE)};
   assign base    = id_mode ? id_word : mem_word;

   always_comb begin
      shaped    = '0;
      lane_mask = '0;
      unique case (lane_pick(wide, half))
         LANE_WORD: begin
            shaped    = base;
            lane_mask = '1;
         end
         LANE_BYTE_LO: begin
            shaped    = {{HI_W{1'b0}}, base[LANE_W-1:0]};
            lane_mask = LOW_MASK;
         end
         LANE_BYTE_HI: begin
            shaped    = {{HI_W{1'b0}},
                         (id_mode ? base[LANE_W-1:0] : base[DQ_W-1:LANE_W])};
            lane_mask = LOW_MASK;
         end
         default: begin
            shaped    = '0;
            lane_mask = '0;
         end
      endcase
   end

   for (genvar b = 0; b < DQ_W; b++) begin : g_bit
      assign dq_oe[b]  = drive & lane_mask[b];
      assign dq_out[b] = dq_oe[b] & shaped[b];
   end

endmodule

// File: rtl/rom_read_port.sv
module rom_read_port
   import rom_port_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned DEPTH_LOG2 = 10,
   parameter int unsigned T_ACC      = 7,
   parameter int unsigned T_OE       = 4,
   parameter logic [7:0]  MFG_CODE   = 8'h20,
   parameter logic [7:0]  DEV_CODE   = 8'hB1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce_n,
   input  logic                  oe_n,
   input  logic                  word_mode,
   input  logic                  id_mode,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  top_pin_in,
   input  logic                  pl_we,
   input  logic [DEPTH_LOG2-1:0] pl_addr,
   input  logic [15:0]           pl_data,
   output logic [15:0]           dq_out,
   output logic [15:0]           dq_oe,
   output logic                  data_valid
);
   localparam int unsigned KEY_W = ADDR_W + 3;

   generate
      if (DEPTH_LOG2 > ADDR_W) begin : g_bad_map
         $error("rom_read_port: array deeper than the address space");
      end
      if (DQ_W != 16) begin : g_bad_dq
         $error("rom_read_port: port is sixteen bits");
      end
   endgenerate

   logic             half_sel;
   logic [KEY_W-1:0] access_key;
   logic [DQ_W-1:0]  mem_word;
   logic             ready;

   // in word mode the shared pin is an output, so its sampled value is ignored
   assign half_sel   = !word_mode && top_pin_in;
   assign access_key = {id_mode, word_mode, half_sel, addr};

   rom_store #(
      .DEPTH_LOG2 (DEPTH_LOG2),
      .DATA_W     (DQ_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (pl_we),
      .wr_addr (pl_addr),
      .wr_data (pl_data),
      .rd_addr (addr[DEPTH_LOG2-1:0]),
      .rd_data (mem_word)
   );

   rom_access_timer #(
      .T_ACC (T_ACC),
      .T_OE  (T_OE),
      .KEY_W (KEY_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .oe_n  (oe_n),
      .key   (access_key),
      .ready (ready)
   );

   rom_lane_mux #(
      .MFG_CODE (MFG_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_mux (
      .wide     (word_mode),
      .half     (half_sel),
      .id_mode  (id_mode),
      .id_sel   (addr[0]),
      .drive    (ready),
      .mem_word (mem_word),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

   assign data_valid = ready;

   p_word_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_mode && data_valid) |-> (dq_oe == 16'hFFFF));

   p_byte_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !word_mode |-> (dq_oe[15:8] == 8'h00));

   p_oe_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |-> (dq_oe == 16'h0000 && !data_valid));

   p_standby_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (dq_oe == 16'h0000 && !data_valid));

   p_id_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && data_valid) |-> (dq_out[15:8] == 8'h00));

endmodule

// File: tb/rom_read_port_test.sv
module rom_read_port_test;
   localparam int unsigned AW  = 6;
   localparam int unsigned DL  = 4;
   localparam int unsigned TA  = 3;
   localparam int unsigned TO  = 2;
   localparam int unsigned NW  = 1 << DL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          word_mode = 1'b1;
   logic          id_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          top_pin_in = 1'b0;
   logic          pl_we = 1'b0;
   logic [DL-1:0] pl_addr = '0;
   logic [15:0]   pl_data = '0;
   logic [15:0]   dq_out;
   logic [15:0]   dq_oe;
   logic          data_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rom_read_port #(
      .ADDR_W (AW), .DEPTH_LOG2 (DL), .T_ACC (TA), .T_OE (TO)
   ) uut (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n),
      .word_mode (word_mode), .id_mode (id_mode), .addr (addr),
      .top_pin_in (top_pin_in), .pl_we (pl_we), .pl_addr (pl_addr),
      .pl_data (pl_data), .dq_out (dq_out), .dq_oe (dq_oe),
      .data_valid (data_valid)
   );

   function automatic logic [15:0] pat(input int i);
      return 16'((i * 4957) ^ 16'hA5C3);
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   // inputs were just changed; edge 0 is the next rising edge
   task automatic settle(input string req, input int t,
                         input logic [15:0] exp_oe, input logic [15:0] exp_out);
      #1;
      chk({req, " R8 drop"}, {15'd0, data_valid}, 16'd0);
      for (int k = 0; k <= t; k++) begin
         tick();
         if (k == t - 1) begin
            chk({req, " early"}, {15'd0, data_valid}, 16'd0);
            chk({req, " early oe"}, dq_oe, 16'h0000);
         end
      end
      chk({req, " valid"}, {15'd0, data_valid}, 16'd1);
      chk({req, " oe"}, dq_oe, exp_oe);
      chk({req, " data"}, dq_out, exp_out);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R9: reset holds outputs released even with both controls active
      ce_n = 1'b0;
      oe_n = 1'b0;
      repeat (4) tick();
      chk("R9 valid", {15'd0, data_valid}, 16'd0);
      chk("R9 oe", dq_oe, 16'h0000);
      ce_n = 1'b1;
      rst_n = 1'b1;
      tick();

      for (int i = 0; i < int'(NW); i++) begin
         pl_we = 1'b1;
         pl_addr = DL'(i);
         pl_data = pat(i);
         tick();
      end
      pl_we = 1'b0;

      // R4: standby with output enable low
      repeat (6) tick();
      chk("R4 standby oe", dq_oe, 16'h0000);
      chk("R4 standby valid", {15'd0, data_valid}, 16'd0);

      // R6: chip select falls, T_ACC wait
      ce_n = 1'b0;
      settle("R6 ce fall", TA, 16'hFFFF, pat(0));

      // R1, R10, R8: word sweep across four times the depth
      for (int a = 1; a < 4 * int'(NW); a++) begin
         addr = AW'(a);
         settle("R1 R10 word", TA, 16'hFFFF, pat(a % int'(NW)));
      end

      // R2: byte sweep, both halves; top-pin change restarts (R8)
      word_mode = 1'b0;
      for (int a = 0; a < int'(NW); a++) begin
         for (int h = 0; h < 2; h++) begin
            addr = AW'(a);
            top_pin_in = h[0];
            settle("R2 byte", TA, 16'h00FF,
                   h ? {8'h00, pat(a)[15:8]} : {8'h00, pat(a)[7:0]});
         end
      end

      // R3: output enable high releases at once
      oe_n = 1'b1;
      #1;
      chk("R3 oe high now", dq_oe, 16'h0000);
      repeat (3) tick();
      chk("R3 oe high", dq_oe, 16'h0000);
      chk("R3 valid", {15'd0, data_valid}, 16'd0);

      // R7: output enable falls, T_OE wait
      oe_n = 1'b0;
      settle("R7 oe fall", TO, 16'h00FF, {8'h00, pat(NW - 1)[15:8]});

      // R4: standby regardless of output enable
      ce_n = 1'b1;
      #1;
      chk("R4 ce high now", dq_oe, 16'h0000);
      oe_n = 1'b1;
      repeat (3) tick();
      chk("R4 both high", dq_oe, 16'h0000);
      oe_n = 1'b0;
      tick();
      chk("R4 oe low", dq_oe, 16'h0000);
      ce_n = 1'b0;
      settle("R6 ce fall byte", TA, 16'h00FF, {8'h00, pat(NW - 1)[15:8]});

      // R5: identification codes
      word_mode = 1'b1;
      id_mode = 1'b1;
      addr = AW'(0);
      settle("R5 word mfg", TA, 16'hFFFF, 16'h0020);
      addr = AW'(1);
      settle("R5 word dev", TA, 16'hFFFF, 16'h00B1);
      addr = AW'(6);
      settle("R5 word mfg even", TA, 16'hFFFF, 16'h0020);
      word_mode = 1'b0;
      top_pin_in = 1'b1;
      addr = AW'(1);
      settle("R5 byte dev hi", TA, 16'h00FF, 16'h00B1);
      top_pin_in = 1'b0;
      addr = AW'(0);
      settle("R5 byte mfg lo", TA, 16'h00FF, 16'h0020);

      // R8: leaving identification mode restarts and returns array data
      id_mode = 1'b0;
      settle("R8 id off", TA, 16'h00FF, {8'h00, pat(0)[7:0]});
      word_mode = 1'b1;
      settle("R8 width change", TA, 16'hFFFF, pat(0));

      summary();
      $finish;
   end

endmodule